// File: doc/BRIEF.md
# Accelerometer SPI Target with Conversion Readback

This block is the serial front end of a three-axis motion sensor. A host talks to it over a four-wire SPI link in mode 0 (data sampled on the rising SCLK edge and changed on the falling edge, MSB first, active-low select). The first byte of every transaction is a command. Bit 7 of the command is the direction, with 1 for a read and 0 for a write. Bits 6:0 give the register address. A write is two bytes long: the command and one data byte. A read returns register contents starting with the byte after the command.

A read aimed at one of the eight result bytes (addresses 0x00 to 0x07) also starts a conversion. The block raises a busy flag while a stub converter waits a fixed number of clocks and then latches all four channel inputs. The host is expected to hold SCLK low during that time. The result is then returned left-justified in two bytes. After that the block keeps streaming bytes with an auto-incrementing pointer until select rises. Clocking the link while the conversion is running yields zero bytes and sets a sticky overrun flag.

All link inputs are brought into the system clock domain through synchronizers. SCLK must therefore run slowly compared with `clk`: each SCLK phase has to last several system clocks.

Top module: `spi_accel_target`

## Requirements
- R1: After reset the serial output is disabled and busy is low. The configuration registers read back 0xE1 (address 0x0C) and 0x40 (address 0x0D), and the status register (address 0x0E) reads 0x00.
- R2: The output enable is high only while select is low and the transaction is in a read data phase. It stays low during every command byte and during the whole of a write.
- R3: A write command with address 0x0C or 0x0D, followed by a data byte, stores that byte, and a later read returns it.
- R4: A write to any other address (for example 0x0A, 0x0E or 0x02) changes no readable register.
- R5: If select rises before the eighth bit of a write data byte, the target register is left unchanged.
- R6: In a read, the byte that follows the command returns the addressed register MSB first. Each bit is present before the rising SCLK edge on which the host samples it.
- R7: While streaming, the pointer steps 0x00 through 0x07 in order, then 0x0C, 0x0D, 0x0E, and then wraps to 0x00.
- R8: A read of an address from 0x00 to 0x07 raises busy once the command byte completes. Busy falls once the converter has latched its result, at most CONV_CYCLES+2 clocks later.
- R9: Channel c (0 = X, 1 = Y, 2 = Z, 3 = auxiliary) occupies addresses 2c and 2c+1. The high byte is value[11:4] and the low byte is {value[3:0], 4'b0000}. Readback starts at the requested byte and then continues through the later result bytes and the registers, following the order in R7.
- R10: A byte clocked while busy is high reads as 0x00 and does not advance the pointer, so the requested byte follows once the result is ready. Any SCLK rising edge seen while busy sets status bit 0, the overrun flag.
- R11: Status bit 0 is returned and then cleared whenever the status byte is loaded for transmission. A second read therefore returns 0x00.
- R12: Raising select ends the transaction and discards the pointer. The next transaction starts from its own command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host (mode 0) |
| spi_mosi | input | 1 | Serial data from the host |
| chan_x | input | CH_W | X-axis sample presented to the converter stub |
| chan_y | input | CH_W | Y-axis sample presented to the converter stub |
| chan_z | input | CH_W | Z-axis sample presented to the converter stub |
| chan_aux | input | CH_W | Auxiliary sample presented to the converter stub |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Drive enable for spi_miso; low means high impedance |
| conv_busy | output | 1 | High while a conversion is in progress |

## Verification
The bench starts a conversion in the middle of the result map, at the Z channel, to show that the stream picks up from the requested byte. If the pointer were reset to X, or the low byte not padded on the right, the expected Z and auxiliary bytes would not match. It clocks a full byte during the conversion: a design that advanced the pointer on that stalled byte would return the Y low byte where the Y high byte belongs, and one without the overrun flag would read status as 0x00. It aborts a write halfway through its data byte, which catches a register updated on partial data. Finally it streams past 0x0E to check the wrap to 0x00. A pointer that skipped or repeated a register would shift every later byte.

// File: rtl/spi_accel_pkg.sv
// Shared constants, phase type and pointer stepping for the accelerometer SPI target.
// Assumes 7-bit register addresses; the command MSB carries the direction.
package spi_accel_pkg;

    localparam logic [6:0] ADR_RES_LAST = 7'h07;
    localparam logic [6:0] ADR_CFG_LO   = 7'h0C;
    localparam logic [6:0] ADR_CFG_HI   = 7'h0D;
    localparam logic [6:0] ADR_STATUS   = 7'h0E;

    localparam logic [7:0] CFG_LO_RST   = 8'hE1;
    localparam logic [7:0] CFG_HI_RST   = 8'h40;

    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_WDATA  = 2'd1,
        PH_DONE   = 2'd2,
        PH_STREAM = 2'd3
    } phase_t;

    // Next address in the readback order; unmapped addresses stay put.
    function automatic logic [6:0] step_addr(input logic [6:0] a);
        logic [6:0] n;
        if (a < ADR_RES_LAST)       n = a + 7'd1;
        else if (a == ADR_RES_LAST) n = ADR_CFG_LO;
        else if (a == ADR_CFG_LO)   n = ADR_CFG_HI;
        else if (a == ADR_CFG_HI)   n = ADR_STATUS;
        else if (a == ADR_STATUS)   n = 7'h00;
        else                        n = a;
        return n;
    endfunction

endpackage

// File: rtl/spi_link_sync.sv
// Brings the SPI pins into the clk domain and detects SCLK edges.
// Assumes every SCLK phase lasts well beyond STAGES+1 system clocks.
module spi_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic              sclk_d;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk};
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    // Edge strobes and synchronized levels.
    always_comb begin
        sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
        sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
        sel       = ~cs_q[STAGES-1];
        mosi_s    = mosi_q[STAGES-1];
    end
endmodule

// File: rtl/conv_stub.sv
// Stand-in for the analog converter: after a start pulse it waits CONV_CYCLES
// clocks, then latches all four channel inputs and pulses done for one clock.
module conv_stub #(
    parameter int CH_W        = 12,
    parameter int CONV_CYCLES = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [3:0][CH_W-1:0]      chan_in,
    output logic                      done,
    output logic [3:0][CH_W-1:0]      result
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             running;

    // Count down the conversion time and capture the samples at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt     <= CNT_W'(CONV_CYCLES - 1);
                running <= 1'b1;
            end else if (running) begin
                if (cnt == '0) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                    result  <= chan_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_accel_target.sv
// SPI mode-0 target for the accelerometer register file with conversion readback.
// Assumes 9 <= CH_W <= 15 and SCLK much slower than clk.
module spi_accel_target #(
    parameter int CH_W        = 12,
    parameter int CONV_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_cs_n,
    input  logic            spi_sclk,
    input  logic            spi_mosi,
    input  logic [CH_W-1:0] chan_x,
    input  logic [CH_W-1:0] chan_y,
    input  logic [CH_W-1:0] chan_z,
    input  logic [CH_W-1:0] chan_aux,
    output logic            spi_miso,
    output logic            spi_miso_en,
    output logic            conv_busy
);
    import spi_accel_pkg::*;

    localparam int N_CH    = 4;
    localparam int LO_BITS = CH_W - 8;
    localparam int PAD     = 8 - LO_BITS;

    logic sclk_rise, sclk_fall, sel, mosi_s;
    logic [N_CH-1:0][CH_W-1:0] chan_in, result;
    logic conv_done, conv_start;

    phase_t     phase;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh, rx_next, ld_val;
    logic [6:0] wr_addr, ptr, ld_addr;
    logic [7:0] cfg_lo, cfg_hi;
    logic       ovr, busy, drive, byte_done;
    logic [7:0] hi_b [N_CH];
    logic [7:0] lo_b [N_CH];

    spi_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sel(sel), .mosi_s(mosi_s)
    );

    assign chan_in = {chan_aux, chan_z, chan_y, chan_x};

    conv_stub #(.CH_W(CH_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .chan_in(chan_in),
        .done(conv_done), .result(result)
    );

    // Split each latched channel into a high byte and a right-padded low byte.
    for (genvar g = 0; g < N_CH; g++) begin : g_bytes
        assign hi_b[g] = result[g][CH_W-1 -: 8];
        assign lo_b[g] = {result[g][LO_BITS-1:0], {PAD{1'b0}}};
    end

    // Incoming byte, byte boundary and the address whose contents get loaded next.
    always_comb begin
        rx_next   = {rx_sh[6:0], mosi_s};
        byte_done = sclk_rise && (bit_cnt == 3'd7);
        ld_addr   = (phase == PH_CMD) ? rx_next[6:0] : ptr;
    end

    // Register read mux.
    always_comb begin
        ld_val = 8'h00;
        if (ld_addr <= ADR_RES_LAST)
            ld_val = ld_addr[0] ? lo_b[ld_addr[2:1]] : hi_b[ld_addr[2:1]];
        else if (ld_addr == ADR_CFG_LO) ld_val = cfg_lo;
        else if (ld_addr == ADR_CFG_HI) ld_val = cfg_hi;
        else if (ld_addr == ADR_STATUS) ld_val = {7'd0, ovr};
    end

    // Transaction sequencer: shifting, command decode, writes, pointer and conversion control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_CMD;
            bit_cnt    <= 3'd0;
            rx_sh      <= 8'h00;
            tx_sh      <= 8'h00;
            wr_addr    <= 7'd0;
            ptr        <= 7'd0;
            cfg_lo     <= CFG_LO_RST;
            cfg_hi     <= CFG_HI_RST;
            ovr        <= 1'b0;
            busy       <= 1'b0;
            drive      <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (conv_done) busy <= 1'b0;
            if (!sel) begin
                phase   <= PH_CMD;
                bit_cnt <= 3'd0;
                tx_sh   <= 8'h00;
                drive   <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    rx_sh   <= rx_next;
                    if (busy && phase == PH_STREAM) ovr <= 1'b1;
                end
                if (sclk_fall && bit_cnt != 3'd0 && phase == PH_STREAM)
                    tx_sh <= {tx_sh[6:0], 1'b0};
                if (conv_done && phase == PH_STREAM && bit_cnt == 3'd0 && !sclk_rise) begin
                    tx_sh <= ld_val;
                    ptr   <= step_addr(ptr);
                end
                if (byte_done) begin
                    case (phase)
                        PH_CMD: begin
                            if (rx_next[7]) begin
                                phase <= PH_STREAM;
                                drive <= 1'b1;
                                if (rx_next[6:0] <= ADR_RES_LAST) begin
                                    busy       <= 1'b1;
                                    conv_start <= 1'b1;
                                    tx_sh      <= 8'h00;
                                    ptr        <= rx_next[6:0];
                                end else begin
                                    tx_sh <= ld_val;
                                    ptr   <= step_addr(rx_next[6:0]);
                                    if (rx_next[6:0] == ADR_STATUS) ovr <= 1'b0;
                                end
                            end else begin
                                phase   <= PH_WDATA;
                                wr_addr <= rx_next[6:0];
                            end
                        end
                        PH_WDATA: begin
                            if (wr_addr == ADR_CFG_LO) cfg_lo <= rx_next;
                            if (wr_addr == ADR_CFG_HI) cfg_hi <= rx_next;
                            phase <= PH_DONE;
                        end
                        PH_STREAM: begin
                            if (busy) begin
                                tx_sh <= 8'h00;
                            end else begin
                                tx_sh <= ld_val;
                                ptr   <= step_addr(ptr);
                                if (ptr == ADR_STATUS) ovr <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Pin outputs; the enable drops at once when select rises.
    always_comb begin
        spi_miso    = tx_sh[7];
        spi_miso_en = drive & ~spi_cs_n;
        conv_busy   = busy;
    end
endmodule

// File: rtl/spi_accel_chk.sv
// Property checker for spi_accel_target, attached by bind below.
module spi_accel_chk #(
    parameter int CONV_CYCLES = 256
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  spi_cs_n,
    input logic                  spi_miso,
    input logic                  spi_miso_en,
    input logic                  conv_busy,
    input logic [7:0]            cfg_lo,
    input logic [7:0]            cfg_hi,
    input logic                  ovr,
    input spi_accel_pkg::phase_t phase
);
    import spi_accel_pkg::*;

    int busy_len;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_len <= 0;
        else if (conv_busy) busy_len <= busy_len + 1;
        else                busy_len <= 0;
    end

    // R2
    miso_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_en |-> !spi_cs_n);

    // R2
    miso_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_en |-> phase == PH_STREAM);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= CONV_CYCLES + 2);

    // R10
    busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && spi_miso_en) |-> !spi_miso);

    // R4
    cfg_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_lo) |-> $past(phase) == PH_WDATA);

    // R4
    cfg_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_hi) |-> $past(phase) == PH_WDATA);

    // R10
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(conv_busy));
endmodule

bind spi_accel_target spi_accel_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .spi_miso_en(spi_miso_en), .conv_busy(conv_busy), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .ovr(ovr), .phase(phase)
);

// File: tb/spi_accel_target_test.sv
// Scoreboard bench: driver tasks queue expected read bytes, a monitor compares them.
module spi_accel_target_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int CONV  = 400;
    localparam int CH_W  = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic [CH_W-1:0] chan_x = 12'hA5C, chan_y = 12'h3F1, chan_z = 12'h800, chan_aux = 12'h127;
    logic spi_miso, spi_miso_en, conv_busy;

    int n_chk = 0, n_err = 0;
    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    logic [7:0] rx_byte;
    event got;

    spi_accel_target #(.CH_W(CH_W), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .chan_x(chan_x), .chan_y(chan_y), .chan_z(chan_z),
        .chan_aux(chan_aux), .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
        .conv_busy(conv_busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Shift nbits of b (MSB first); sample SDO just before each rising edge.
    task automatic xfer(input logic [7:0] b, input int nbits, input bit chk,
                        output logic [7:0] r, output bit en_any);
        r = 8'h00; en_any = 1'b0;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = b[i];
            tick(HALF);
            r[i] = spi_miso;
            if (spi_miso_en) en_any = 1'b1;
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
        if (chk) begin
            rx_byte = r;
            -> got;
        end
    endtask

    task automatic sel_on();
        spi_cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(12);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d, input string tag);
        logic [7:0] r; bit en0, en1;
        sel_on();
        xfer({1'b0, a}, 8, 1'b0, r, en0);
        xfer(d, 8, 1'b0, r, en1);
        sel_off();
        check({tag, " R2 write keeps SDO off"}, 16'(en0 | en1), 16'd0);
    endtask

    // Read command then nb streamed bytes, each checked against the given list.
    task automatic rd_stream(input logic [6:0] a, input logic [7:0] vals [], input string tag);
        logic [7:0] r; bit en;
        sel_on();
        xfer({1'b1, a}, 8, 1'b0, r, en);
        check({tag, " R2 command keeps SDO off"}, 16'(en), 16'd0);
        foreach (vals[k]) begin
            expect_byte(vals[k], $sformatf("%s byte %0d", tag, k));
            xfer(8'h00, 8, 1'b1, r, en);
        end
        sel_off();
    endtask

    // Monitor: pops one expectation for every captured byte.
    initial begin
        forever begin
            @(got);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 16'(rx_byte), 16'hFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, 16'(rx_byte), 16'(e.v));
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] r; bit en;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check("R1 SDO disabled after reset", 16'(spi_miso_en), 16'd0);
        check("R1 busy low after reset", 16'(conv_busy), 16'd0);
        rd_stream(7'h0C, '{8'hE1}, "R1 R6 cfg low reset");
        rd_stream(7'h0D, '{8'h40}, "R1 R6 cfg high reset");
        rd_stream(7'h0E, '{8'h00}, "R1 status reset");

        wr_reg(7'h0C, 8'h5A, "R3 cfg low");
        wr_reg(7'h0D, 8'hC3, "R3 cfg high");
        rd_stream(7'h0C, '{8'h5A}, "R3 cfg low readback");
        rd_stream(7'h0D, '{8'hC3}, "R3 cfg high readback");

        wr_reg(7'h0E, 8'hFF, "R4 status");
        wr_reg(7'h02, 8'h11, "R4 result");
        wr_reg(7'h0A, 8'h77, "R4 key");
        rd_stream(7'h0C, '{8'h5A, 8'hC3, 8'h00}, "R4 regs unchanged");

        // R5: select rises after 4 bits of the data byte.
        sel_on();
        xfer(8'h0C, 8, 1'b0, r, en);
        xfer(8'h99, 4, 1'b0, r, en);
        sel_off();
        rd_stream(7'h0C, '{8'h5A}, "R5 aborted write");

        // R8 R9 R7: conversion at X, stream through registers and wrap.
        sel_on();
        xfer(8'h80, 8, 1'b0, r, en);
        tick(1);
        check("R8 busy after command", 16'(conv_busy), 16'd1);
        tick(CONV + 10);
        check("R8 busy clears after conversion", 16'(conv_busy), 16'd0);
        foreach (exp_vals_x[k]) begin
            expect_byte(exp_vals_x[k], $sformatf("R9 R7 stream from X byte %0d", k));
            xfer(8'h00, 8, 1'b1, r, en);
            check("R2 SDO driven in read", 16'(en), 16'd1);
        end
        sel_off();
        check("R2 SDO off after select", 16'(spi_miso_en), 16'd0);

        // R7 R12: new transaction starts from its own address.
        rd_stream(7'h0D, '{8'hC3, 8'h00, 8'hA5}, "R12 R7 from 0x0D");

        // R9: conversion requested at Z with new samples.
        chan_z = 12'h7FF; chan_aux = 12'hB3D;
        sel_on();
        xfer(8'h84, 8, 1'b0, r, en);
        tick(CONV + 10);
        foreach (exp_vals_z[k]) begin
            expect_byte(exp_vals_z[k], $sformatf("R9 stream from Z byte %0d", k));
            xfer(8'h00, 8, 1'b1, r, en);
        end
        sel_off();

        // R10: clock a byte during the conversion.
        chan_y = 12'h6D2;
        sel_on();
        xfer(8'h82, 8, 1'b0, r, en);
        expect_byte(8'h00, "R10 byte during busy");
        xfer(8'h00, 8, 1'b1, r, en);
        tick(1);
        check("R10 still busy after stalled byte", 16'(conv_busy), 16'd1);
        tick(CONV);
        expect_byte(8'h6D, "R10 Y high after stall");
        xfer(8'h00, 8, 1'b1, r, en);
        expect_byte(8'h20, "R10 Y low after stall");
        xfer(8'h00, 8, 1'b1, r, en);
        sel_off();

        rd_stream(7'h0E, '{8'h01}, "R10 R11 overrun flag set");
        rd_stream(7'h0E, '{8'h00}, "R11 overrun flag cleared");

        tick(20);
        check("scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Expected stream values, derived from R7 and R9.
    logic [7:0] exp_vals_x [12] = '{8'hA5, 8'hC0, 8'h3F, 8'h10, 8'h80, 8'h00, 8'h12, 8'h70,
                                     8'h5A, 8'hC3, 8'h00, 8'hA5};
    logic [7:0] exp_vals_z [6]  = '{8'h7F, 8'hF0, 8'hB3, 8'hD0, 8'h5A, 8'hC3};
endmodule